// File: doc/BRIEF.md
# Synchronous FIFO with Rewind and Replay

This block is a single-clock FIFO that can replay its contents. Words enter through an active-low write strobe and leave through a registered output that an active-low read strobe advances. The output behaviour is fixed at master reset. In standard mode, every word needs a read strobe. In first-word-fall-through mode, the head word moves to the output by itself. The status pins change meaning with the mode, as R4 describes.

A rewind request moves the read pointer back to storage location zero, so that the words written since the last reset can be read again. Master reset chooses how the rewind behaves. With normal latency, a short setup window follows the request before replay begins. With zero latency, the first replayed word is on the output right after the request edge.

An asynchronous partial reset empties the FIFO and leaves the mode, the latency choice and both offset registers untouched. Three threshold flags report the fill level: almost-empty, almost-full and half-full. The almost-empty and almost-full thresholds come from offset registers that are loaded through a parallel port.

Top module: `fifo_rt`

## Requirements
- R1: With `mrst_n` low on a clock edge, the block takes its mode from `cfg_fwft` (1 = fall-through) and its rewind latency from `cfg_rtlat` (0 = zero latency, 1 = normal). It clears both pointers, sets both offsets to 2 and zeroes `rdata`. Afterwards `rd_stat`=0 and `wr_stat`=1 in standard mode, and `rd_stat`=1 and `wr_stat`=0 in fall-through mode.
- R2: In standard mode, `rd_n` low on an edge loads the next stored word into `rdata` at that edge when the level is non-zero. When the FIFO is empty the strobe is ignored and `rdata` keeps its value.
- R3: `wr_n` low on an edge stores `wdata` when the storage level is below DEPTH. A write at level DEPTH is dropped and overwrites nothing.
- R4: In standard mode, `rd_stat` is 1 exactly when the level is non-zero and no rewind setup is pending, and `wr_stat` is 0 exactly when the level equals DEPTH. In fall-through mode, `rd_stat` is 0 exactly when a valid word sits in `rdata`, and `wr_stat` is 1 exactly when the storage level equals DEPTH.
- R5: With level L counting the stored words not yet moved to `rdata`: `pae` is 0 when L <= the almost-empty offset, `paf` is 0 when L >= DEPTH minus the almost-full offset, and `hf` is 0 when L > DEPTH/2.
- R6: `ofs_ld_n` low on an edge loads `ofs_val` into the almost-empty offset when `ofs_sel`=0, or into the almost-full offset when `ofs_sel`=1.
- R7: In fall-through mode, the head stored word is moved into `rdata` on any edge where the output holds no valid word or is being consumed (`rd_n` low). Each later word needs `rd_n` low on an edge.
- R8: `prst_n` low acts at once, without a clock. It clears both pointers and `rdata`, gives `pae`=0, `paf`=1 and `hf`=1, and sets `rd_stat`/`wr_stat` to the reset values of the current mode. The mode, the latency choice and both offsets are kept.
- R9: With normal latency, `rt_n` low on an edge rewinds the read pointer and opens a setup window of 2 edges. During the window `rd_stat` is 0 in standard mode and 1 in fall-through mode. After the window, standard reads restart at location zero, and in fall-through mode word zero is loaded on the next edge.
- R10: With zero latency, `rt_n` low on an edge loads the word at location zero into `rdata` on that same edge and points the read pointer at location one. `rd_n` on that edge is ignored. In fall-through mode `rd_stat` is 0 after that edge.
- R11: After a rewind, the level equals the number of words written since the last reset (at most DEPTH), and all flags follow that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| mrst_n | input | 1 | Synchronous master reset, active low |
| prst_n | input | 1 | Asynchronous partial reset, active low |
| cfg_fwft | input | 1 | Mode select, sampled at master reset |
| cfg_rtlat | input | 1 | Rewind latency select, sampled at master reset (0 = zero) |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | DW | Write data |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Rewind request, active low |
| ofs_ld_n | input | 1 | Offset load strobe, active low |
| ofs_sel | input | 1 | Offset target: 0 almost-empty, 1 almost-full |
| ofs_val | input | AW | Offset value |
| rdata | output | DW | Registered read data |
| rd_stat | output | 1 | Empty flag (standard) or output-ready flag (fall-through) |
| wr_stat | output | 1 | Full flag (standard) or input-ready flag (fall-through) |
| pae | output | 1 | Almost-empty flag, active low |
| paf | output | 1 | Almost-full flag, active low |
| hf | output | 1 | Half-full flag, active low |

## Verification
The bench builds the block with its defaults: 16 words of 18 bits and a 2-edge setup window. The small depth lets the bench step through every fill level from 0 to 16 and check all five flags against thresholds it computes itself. At the same depth it can write past full, drain past empty and rewind from a completely full history. Each rewind latency is run in both output modes, and partial reset is checked mid-cycle in both modes, with reloaded offsets that differ from the defaults so that keeping them shows at the threshold crossings.

// File: rtl/fifo_rt_pkg.sv
`timescale 1ns/1ps
// Shared configuration types for the rewindable FIFO.
package fifo_rt_pkg;
    typedef enum logic { MODE_STD = 1'b0, MODE_FWFT = 1'b1 } out_mode_e;
    typedef enum logic { LAT_ZERO = 1'b0, LAT_NORMAL = 1'b1 } rt_lat_e;

    typedef struct packed {
        out_mode_e mode;
        rt_lat_e   lat;
    } fifo_cfg_t;
endpackage

// File: rtl/fifo_rt_cfg.sv
`timescale 1ns/1ps
// Configuration and offset registers.
// The mode and latency are captured only at master reset. The offsets get
// their defaults at master reset and are reloaded through a parallel port.
// This block has no partial-reset input, so its state survives partial reset.
module fifo_rt_cfg
    import fifo_rt_pkg::*;
#(
    parameter int AW      = 4,
    parameter int PAE_DEF = 2,
    parameter int PAF_DEF = 2
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          cfg_fwft,
    input  logic          cfg_rtlat,
    input  logic          ofs_ld_n,
    input  logic          ofs_sel,
    input  logic [AW-1:0] ofs_val,
    output fifo_cfg_t     cfg_q,
    output logic [AW-1:0] pae_ofs,
    output logic [AW-1:0] paf_ofs
);
    localparam logic [AW-1:0] PAE_INIT = AW'(PAE_DEF);
    localparam logic [AW-1:0] PAF_INIT = AW'(PAF_DEF);

    // Capture the configuration at master reset and accept offset loads.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            cfg_q.mode <= out_mode_e'(cfg_fwft);
            cfg_q.lat  <= rt_lat_e'(cfg_rtlat);
            pae_ofs    <= PAE_INIT;
            paf_ofs    <= PAF_INIT;
        end else if (!ofs_ld_n) begin
            if (ofs_sel) paf_ofs <= ofs_val;
            else         pae_ofs <= ofs_val;
        end
    end
endmodule

// File: rtl/fifo_rt_ram.sv
`timescale 1ns/1ps
// Storage array: one synchronous write port and one combinational read port.
// The read value is registered by the caller.
module fifo_rt_ram #(
    parameter int DW = 18,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rd_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store the incoming word when a write is granted.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the addressed word without a clock.
    assign rd_q = mem[raddr];
endmodule

// File: rtl/fifo_rt_flags.sv
`timescale 1ns/1ps
// Threshold flags derived from the storage level. All flags are active low.
// The level is assumed to lie between 0 and DEPTH.
module fifo_rt_flags #(
    parameter int AW = 4
) (
    input  logic [AW:0]   lvl,
    input  logic [AW-1:0] pae_ofs,
    input  logic [AW-1:0] paf_ofs,
    output logic          pae,
    output logic          paf,
    output logic          hf
);
    localparam logic [AW:0] DEPTH_L = {1'b1, {AW{1'b0}}};
    localparam logic [AW:0] HALF_L  = DEPTH_L >> 1;

    logic [AW:0] paf_thr;

    // Compare the level against the near-empty, near-full and midpoint limits.
    always_comb begin
        paf_thr = DEPTH_L - {1'b0, paf_ofs};
        pae     = ~(lvl <= {1'b0, pae_ofs});
        paf     = ~(lvl >= paf_thr);
        hf      = ~(lvl > HALF_L);
    end
endmodule

// File: rtl/fifo_rt.sv
`timescale 1ns/1ps
// Rewindable synchronous FIFO, top level.
// Assumes one clock for both ports. A rewind replays the words written since
// the last reset, up to DEPTH of them. mrst_n is synchronous; prst_n is
// asynchronous and leaves the configuration registers alone.
module fifo_rt
    import fifo_rt_pkg::*;
#(
    parameter int DW        = 18,
    parameter int AW        = 4,
    parameter int SETUP_CYC = 2,
    parameter int PAE_DEF   = 2,
    parameter int PAF_DEF   = 2
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          cfg_fwft,
    input  logic          cfg_rtlat,
    input  logic          wr_n,
    input  logic [DW-1:0] wdata,
    input  logic          rd_n,
    input  logic          rt_n,
    input  logic          ofs_ld_n,
    input  logic          ofs_sel,
    input  logic [AW-1:0] ofs_val,
    output logic [DW-1:0] rdata,
    output logic          rd_stat,
    output logic          wr_stat,
    output logic          pae,
    output logic          paf,
    output logic          hf
);
    localparam int          CW      = $clog2(SETUP_CYC + 1);
    localparam logic [AW:0] DEPTH_L = {1'b1, {AW{1'b0}}};
    localparam logic [CW-1:0] SETUP_INIT = CW'(SETUP_CYC);

    fifo_cfg_t     cfg_q;
    logic [AW-1:0] pae_ofs, paf_ofs;
    logic [AW:0]   wptr, rptr, lvl, lvl_rt, base_ptr;
    logic [CW-1:0] setup_cnt;
    logic          out_vld;
    logic          is_fwft, zero_lat, in_setup;
    logic          rt_req, do_wr, std_rd, take, fw_load, zl_load;
    logic [AW-1:0] raddr;
    logic [DW-1:0] ram_q;

    fifo_rt_cfg #(.AW(AW), .PAE_DEF(PAE_DEF), .PAF_DEF(PAF_DEF)) u_cfg (
        .clk      (clk),
        .mrst_n   (mrst_n),
        .cfg_fwft (cfg_fwft),
        .cfg_rtlat(cfg_rtlat),
        .ofs_ld_n (ofs_ld_n),
        .ofs_sel  (ofs_sel),
        .ofs_val  (ofs_val),
        .cfg_q    (cfg_q),
        .pae_ofs  (pae_ofs),
        .paf_ofs  (paf_ofs)
    );

    fifo_rt_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk  (clk),
        .we   (do_wr),
        .waddr(wptr[AW-1:0]),
        .wdata(wdata),
        .raddr(raddr),
        .rd_q (ram_q)
    );

    fifo_rt_flags #(.AW(AW)) u_flags (
        .lvl    (lvl),
        .pae_ofs(pae_ofs),
        .paf_ofs(paf_ofs),
        .pae    (pae),
        .paf    (paf),
        .hf     (hf)
    );

    // Decode the configuration, the level and this cycle's grants.
    always_comb begin
        is_fwft  = (cfg_q.mode == MODE_FWFT);
        zero_lat = (cfg_q.lat == LAT_ZERO);
        in_setup = (setup_cnt != '0);
        lvl      = wptr - rptr;
        lvl_rt   = (wptr[AW] && (wptr[AW-1:0] == '0)) ? DEPTH_L
                                                      : {1'b0, wptr[AW-1:0]};
        base_ptr = wptr - lvl_rt;
        rt_req   = !rt_n && !in_setup;
        do_wr    = !wr_n && (lvl != DEPTH_L);
        std_rd   = !is_fwft && !rd_n && (lvl != '0) && !in_setup && !rt_req;
        take     = is_fwft && out_vld && !rd_n && !rt_req;
        fw_load  = is_fwft && !in_setup && !rt_req && (lvl != '0)
                   && (!out_vld || take);
        zl_load  = rt_req && zero_lat && (lvl_rt != '0);
        raddr    = zl_load ? base_ptr[AW-1:0] : rptr[AW-1:0];
    end

    // Advance the pointers, rewind on request and count down the setup window.
    always_ff @(posedge clk or negedge prst_n) begin
        if (!prst_n) begin
            wptr      <= '0;
            rptr      <= '0;
            setup_cnt <= '0;
        end else if (!mrst_n) begin
            wptr      <= '0;
            rptr      <= '0;
            setup_cnt <= '0;
        end else begin
            if (do_wr) wptr <= wptr + 1'b1;
            if (rt_req) begin
                rptr      <= zl_load ? base_ptr + 1'b1 : base_ptr;
                setup_cnt <= zero_lat ? '0 : SETUP_INIT;
            end else begin
                if (in_setup)          setup_cnt <= setup_cnt - 1'b1;
                if (std_rd || fw_load) rptr      <= rptr + 1'b1;
            end
        end
    end

    // Update the registered output word and its valid bit.
    always_ff @(posedge clk or negedge prst_n) begin
        if (!prst_n) begin
            rdata   <= '0;
            out_vld <= 1'b0;
        end else if (!mrst_n) begin
            rdata   <= '0;
            out_vld <= 1'b0;
        end else if (rt_req) begin
            if (zl_load) rdata <= ram_q;
            out_vld <= zl_load;
        end else if (std_rd || fw_load) begin
            rdata   <= ram_q;
            out_vld <= 1'b1;
        end else if (take) begin
            out_vld <= 1'b0;
        end
    end

    // Drive the status pins with the meaning the current mode gives them.
    always_comb begin
        if (is_fwft) begin
            rd_stat = !out_vld;
            wr_stat = (lvl == DEPTH_L);
        end else begin
            rd_stat = (lvl != '0) && !in_setup;
            wr_stat = (lvl != DEPTH_L);
        end
    end
endmodule

// File: rtl/fifo_rt_chk.sv
`timescale 1ns/1ps
// Property checker for fifo_rt, attached below by bind.
module fifo_rt_chk #(
    parameter int DW = 18,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          mrst_n,
    input logic          prst_n,
    input logic          wr_n,
    input logic          rd_n,
    input logic          rt_n,
    input logic          rd_stat,
    input logic [DW-1:0] rdata,
    input logic [AW:0]   lvl,
    input logic [AW:0]   wptr,
    input logic          in_setup,
    input logic          is_fwft,
    input logic          zero_lat
);
    localparam logic [AW:0] FULL_L = {1'b1, {AW{1'b0}}};

    AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        lvl <= FULL_L); // R3

    AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (lvl == FULL_L && !wr_n) |=> $stable(wptr)); // R3

    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (!is_fwft && rt_n && !rd_n && !rd_stat) |=> $stable(rdata)); // R2

    AST_SETUP_MARK: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (!zero_lat && !rt_n && !in_setup) |=> (rd_stat == is_fwft)); // R9

    AST_ZL_READY: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (zero_lat && is_fwft && !rt_n && wptr != '0) |=> !rd_stat); // R10

    // Check that a held partial reset keeps the output word and the level at zero.
    always @(posedge clk) begin
        if (!prst_n) begin
            AST_PRST_CLEAR: assert (rdata == '0 && lvl == '0); // R8
        end
    end
endmodule

bind fifo_rt fifo_rt_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .mrst_n  (mrst_n),
    .prst_n  (prst_n),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .rt_n    (rt_n),
    .rd_stat (rd_stat),
    .rdata   (rdata),
    .lvl     (lvl),
    .wptr    (wptr),
    .in_setup(in_setup),
    .is_fwft (is_fwft),
    .zero_lat(zero_lat)
);

// File: tb/fifo_rt_tb.sv
`timescale 1ns/1ps
// Directed sweeps over a 16 x 18 FIFO with expected values computed here.
module fifo_rt_tb;
    localparam int DW = 18;
    localparam int AW = 4;
    localparam int D  = 1 << AW;

    logic          clk = 1'b0;
    logic          mrst_n = 1'b1, prst_n = 1'b1;
    logic          cfg_fwft = 1'b0, cfg_rtlat = 1'b1;
    logic          wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
    logic [DW-1:0] wdata = '0;
    logic          ofs_ld_n = 1'b1, ofs_sel = 1'b0;
    logic [AW-1:0] ofs_val = '0;
    logic [DW-1:0] rdata;
    logic          rd_stat, wr_stat, pae, paf, hf;
    int            nchk = 0, nerr = 0;

    fifo_rt u_dut (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .cfg_fwft(cfg_fwft),
        .cfg_rtlat(cfg_rtlat), .wr_n(wr_n), .wdata(wdata), .rd_n(rd_n),
        .rt_n(rt_n), .ofs_ld_n(ofs_ld_n), .ofs_sel(ofs_sel), .ofs_val(ofs_val),
        .rdata(rdata), .rd_stat(rd_stat), .wr_stat(wr_stat),
        .pae(pae), .paf(paf), .hf(hf)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] val(input int t, input int k);
        return DW'((t << 12) + k * 5 + 3);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic mreset(input logic f, input logic lat);
        mrst_n = 1'b0; cfg_fwft = f; cfg_rtlat = lat;
        tick(); tick();
        mrst_n = 1'b1;
    endtask

    task automatic wr1(input logic [DW-1:0] v);
        wr_n = 1'b0; wdata = v; tick(); wr_n = 1'b1;
    endtask

    task automatic rd1();
        rd_n = 1'b0; tick(); rd_n = 1'b1;
    endtask

    task automatic ldofs(input logic sel, input int v);
        ofs_ld_n = 1'b0; ofs_sel = sel; ofs_val = AW'(v); tick(); ofs_ld_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        tick();
        // ---- standard mode, normal latency ----
        mreset(1'b0, 1'b1);
        chk("R1 rdata", rdata, 0);
        chk("R1 rd_stat", rd_stat, 0);
        chk("R1 wr_stat", wr_stat, 1);
        chk("R5 pae", pae, 0);
        chk("R5 paf", paf, 1);
        chk("R5 hf", hf, 1);
        for (int k = 1; k <= D; k++) begin
            wr1(val(1, k - 1));
            chk("R4 rd_stat", rd_stat, 1);
            chk("R4 wr_stat", wr_stat, (k != D));
            chk("R5 pae", pae, (k > 2));
            chk("R5 paf", paf, !(k >= D - 2));
            chk("R5 hf", hf, !(k > D / 2));
        end
        wr1('1);
        chk("R3 full wr_stat", wr_stat, 0);
        for (int k = 0; k < D; k++) begin
            rd1();
            chk("R2/R3 read data", rdata, val(1, k));
        end
        chk("R4 empty", rd_stat, 0);
        rd1();
        chk("R2 empty read ignored", rdata, val(1, D - 1));
        rt_n = 1'b0; tick(); rt_n = 1'b1;
        chk("R9 setup edge0", rd_stat, 0);
        tick();
        chk("R9 setup edge1", rd_stat, 0);
        tick();
        chk("R9 setup done", rd_stat, 1);
        chk("R11 hf after rewind", hf, 0);
        chk("R11 full after rewind", wr_stat, 0);
        for (int k = 0; k < D; k++) begin
            rd1();
            chk("R9 replay data", rdata, val(1, k));
        end

        // ---- offsets and partial reset, standard mode ----
        mreset(1'b0, 1'b1);
        ldofs(1'b0, 5);
        ldofs(1'b1, 3);
        for (int k = 0; k < 5; k++) wr1(val(2, k));
        rd1();
        chk("R2 read", rdata, val(2, 0));
        #2 prst_n = 1'b0; #1;
        chk("R8 rdata", rdata, 0);
        chk("R8 rd_stat", rd_stat, 0);
        chk("R8 wr_stat", wr_stat, 1);
        chk("R8 pae", pae, 0);
        chk("R8 paf", paf, 1);
        chk("R8 hf", hf, 1);
        tick();
        prst_n = 1'b1;
        tick();
        for (int k = 1; k <= 13; k++) begin
            wr1(val(3, k));
            if (k == 5)  chk("R6/R8 pae kept offset", pae, 0);
            if (k == 6)  chk("R6/R8 pae crossed", pae, 1);
            if (k == 12) chk("R6/R8 paf below", paf, 1);
            if (k == 13) chk("R6/R8 paf kept offset", paf, 0);
        end
        chk("R8 mode kept", rd_stat, 1);

        // ---- master reset restores default offsets ----
        mreset(1'b0, 1'b1);
        for (int k = 0; k < 3; k++) wr1(val(4, k));
        chk("R1 default pae offset", pae, 1);

        // ---- fall-through, normal latency ----
        mreset(1'b1, 1'b1);
        chk("R1 fwft rd_stat", rd_stat, 1);
        chk("R1 fwft wr_stat", wr_stat, 0);
        for (int k = 0; k < 6; k++) begin
            wr_n = 1'b0; wdata = val(5, k); tick();
        end
        wr_n = 1'b1;
        chk("R7 head word", rdata, val(5, 0));
        chk("R7 ready", rd_stat, 0);
        chk("R5 pae level 5", pae, 1);
        for (int k = 1; k < 6; k++) begin
            rd1();
            chk("R7 next word", rdata, val(5, k));
        end
        rd1();
        chk("R7 drained", rd_stat, 1);
        rt_n = 1'b0; tick(); rt_n = 1'b1;
        chk("R9 fwft setup", rd_stat, 1);
        tick(); tick();
        chk("R9 fwft setup end", rd_stat, 1);
        tick();
        chk("R9 fwft word0 ready", rd_stat, 0);
        chk("R9 fwft word0", rdata, val(5, 0));
        for (int k = 1; k < 6; k++) begin
            rd1();
            chk("R9 fwft replay", rdata, val(5, k));
        end

        // ---- fall-through, zero latency, then partial reset ----
        mreset(1'b1, 1'b0);
        for (int k = 0; k < 4; k++) wr1(val(6, k));
        for (int k = 0; k < 4; k++) rd1();
        chk("R7 drained", rd_stat, 1);
        rt_n = 1'b0; rd_n = 1'b0; tick(); rt_n = 1'b1; rd_n = 1'b1;
        chk("R10 fwft ready same edge", rd_stat, 0);
        chk("R10 fwft word0", rdata, val(6, 0));
        chk("R11 level 3", pae, 1);
        for (int k = 1; k < 4; k++) begin
            rd1();
            chk("R10 fwft replay", rdata, val(6, k));
        end
        #2 prst_n = 1'b0; #1;
        chk("R8 fwft rd_stat", rd_stat, 1);
        chk("R8 fwft wr_stat", wr_stat, 0);
        chk("R8 fwft rdata", rdata, 0);
        tick();
        prst_n = 1'b1;
        wr1(val(7, 0));
        tick();
        chk("R8 fwft mode kept", rd_stat, 0);
        chk("R8 fwft word", rdata, val(7, 0));

        // ---- standard mode, zero latency ----
        mreset(1'b0, 1'b0);
        for (int k = 0; k < 3; k++) wr1(val(8, k));
        for (int k = 0; k < 3; k++) rd1();
        chk("R2 last", rdata, val(8, 2));
        rt_n = 1'b0; rd_n = 1'b0; tick(); rt_n = 1'b1; rd_n = 1'b1;
        chk("R10 std word0", rdata, val(8, 0));
        chk("R10 std not empty", rd_stat, 1);
        for (int k = 1; k < 3; k++) begin
            rd1();
            chk("R10 std replay", rdata, val(8, k));
        end
        chk("R11 std empty after replay", rd_stat, 0);

        finish_run();
    end
endmodule